// File: doc/BRIEF.md
# Multi-Level Cell Data Mapper and Level Classifier

This block sits between a memory bank's data path and its analog cell interface. On the write side it turns a data word into one level code per cell, choosing the bit-to-level assignment by the bank being written. That lets redundant copies in different banks place the same data on different physical levels. On the read side it takes one digitised conductance sample per cell, classifies each sample into a level by comparing it against thresholds, and inverts the bank's mapping to recover the data.

Two storage modes are offered. Dense mode keeps two bits in each cell across four levels. Robust mode keeps one bit in each cell, using only the lowest and highest levels. In robust mode the decision threshold is programmable and resets above the midpoint, because disturbances raise low-conductance cells far more than they move high ones. A robust read needs a single comparison and completes in one cycle. A dense read resolves the upper half and then the exact level, so it takes two cycles.

Level codes 0, 1, 2 and 3 stand for the levels targeted at 50, 100, 150 and 200 µS. Samples are unsigned, at 1 µS per LSB. Cell i occupies sample bits [8i+7:8i] and level bits [2i+1:2i].

Top module: `cell_level_codec`

## Requirements
- R1: In dense mode, the write path sets wrLevels of cell i from data bits [2i+1:2i] using the bank's mapping. Bank 0 maps 00,01,10,11 to codes 0,1,2,3. Bank 1 maps them to 3,2,1,0. Bank 2 maps them to 1,3,0,2.
- R2: A bankSel value of 3 behaves exactly like bank 0, on both writes and reads.
- R3: In robust mode, cell i stores data bit i. A 1 becomes code 3 and a 0 becomes code 0 in banks 0, 2 and 3; bank 1 swaps the two. Data bits at index CELLS and above are ignored, and every level output is 0 or 3.
- R4: A dense read classifies each sample by thresholds 75, 125 and 175 into codes 0 to 3, where a sample equal to a threshold takes the upper level. It then decodes the code through the exact inverse of the captured bank's mapping.
- R5: A robust read gives code 3 when the sample is at or above the robust threshold and code 0 otherwise, and decodes it with the R3 polarity. The threshold resets to 160 and takes thrValue on a cycle where thrLoad is high. Result bits at index CELLS and above are 0.
- R6: After reset, rdValid and rdData are 0. A read accepted at a rising edge raises rdValid for one cycle: after that same edge in robust mode, and one edge later in dense mode.
- R7: The samples, bank and mode of a dense read are captured when the read is accepted, so later changes to them do not alter its result. A rdStart during the second cycle of a dense read is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| robustMode | input | 1 | 1 selects one bit per cell, 0 selects two bits per cell |
| bankSel | input | 2 | Bank index that selects the level mapping |
| wrData | input | 2*CELLS | Data word to be written |
| wrLevels | output | 2*CELLS | Level code for each cell, combinational |
| thrLoad | input | 1 | Loads thrValue into the robust threshold |
| thrValue | input | SAMPLE_W | New robust threshold |
| rdStart | input | 1 | Requests a read of rdSamples |
| rdSamples | input | CELLS*SAMPLE_W | Digitised conductance of each cell |
| rdValid | output | 1 | One-cycle strobe that marks rdData as new |
| rdData | output | 2*CELLS | Decoded read word |

## Verification
The bench builds the block with its default parameters: four cells, 8-bit samples, and thresholds 75, 125, 175 and a robust threshold of 160. At this size one 32-bit sample vector reaches all four levels at once, and the boundary samples 74/75, 124/125, 174/175 and 159/160 can be placed side by side in a single read. Each mapping is checked against the same data and samples in every bank, so a swapped entry in any permutation or inverse shows up directly. Reloading the threshold to 100 shows that the robust decision follows the programmed value rather than a fixed one.

// File: rtl/clc_pkg.sv
package clc_pkg;

  typedef logic [1:0] level_t;
  typedef logic [1:0] bank_t;

  typedef struct packed {
    logic capture;
    logic finishRobust;
    logic finishDense;
  } ctrl_strobe_t;

  // data pair -> level code, per bank; index 3 falls back to bank 0
  function automatic level_t encodeSym(bank_t bank, logic [1:0] sym);
    level_t lvl;
    case (bank)
      2'd1: lvl = ~sym;
      2'd2: begin
        case (sym)
          2'b00:   lvl = 2'd1;
          2'b01:   lvl = 2'd3;
          2'b10:   lvl = 2'd0;
          default: lvl = 2'd2;
        endcase
      end
      default: lvl = sym;
    endcase
    return lvl;
  endfunction

  // level code -> data pair, exact inverse of encodeSym
  function automatic logic [1:0] decodeSym(bank_t bank, level_t lvl);
    logic [1:0] sym;
    case (bank)
      2'd1: sym = ~lvl;
      2'd2: begin
        case (lvl)
          2'd0:    sym = 2'b10;
          2'd1:    sym = 2'b00;
          2'd2:    sym = 2'b11;
          default: sym = 2'b01;
        endcase
      end
      default: sym = lvl;
    endcase
    return sym;
  endfunction

  function automatic logic robustInvert(bank_t bank);
    return bank == 2'd1;
  endfunction

endpackage

// File: rtl/clc_write_map.sv
module clc_write_map
  import clc_pkg::*;
#(
  parameter int CELLS  = 4,
  localparam int DATA_W = 2 * CELLS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              robustMode,
  input  bank_t             bankSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] wrLevels
);

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    level_t denseLvl;
    level_t robustLvl;
    always_comb begin
      denseLvl  = encodeSym(bankSel, wrData[2*i +: 2]);
      robustLvl = (wrData[i] ^ robustInvert(bankSel)) ? 2'd3 : 2'd0;
      wrLevels[2*i +: 2] = robustMode ? robustLvl : denseLvl;
    end

    AST_ROBUST_EXTREMES: assert property (@(posedge clk) disable iff (!rstN)
      robustMode |-> (wrLevels[2*i +: 2] == 2'd0 || wrLevels[2*i +: 2] == 2'd3)); // R3
  end

endmodule

// File: rtl/clc_ctrl.sv
module clc_ctrl
  import clc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rdStart,
  input  logic         robustMode,
  input  logic         rdValid,
  output ctrl_strobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_FINE} state_t;
  state_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (rdStart) begin
          strobe.capture = 1'b1;
          if (robustMode) strobe.finishRobust = 1'b1;
          else            nextState = ST_FINE;
        end
      end
      default: begin
        strobe.finishDense = 1'b1;
        nextState          = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  AST_ROBUST_LAT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && rdStart && robustMode) |=> rdValid); // R6
  AST_DENSE_LAT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && rdStart && !robustMode) |=> (!rdValid ##1 rdValid)); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FINE) |=> (state == ST_IDLE)); // R7

endmodule

// File: rtl/clc_datapath.sv
module clc_datapath
  import clc_pkg::*;
#(
  parameter int CELLS    = 4,
  parameter int SAMPLE_W = 8,
  parameter logic [SAMPLE_W-1:0] THR_LO  = 8'd75,
  parameter logic [SAMPLE_W-1:0] THR_MID = 8'd125,
  parameter logic [SAMPLE_W-1:0] THR_HI  = 8'd175,
  parameter logic [SAMPLE_W-1:0] THR_ROBUST_RST = 8'd160,
  localparam int DATA_W = 2 * CELLS,
  localparam int SAMP_BUS_W = CELLS * SAMPLE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobe_t          strobe,
  input  logic                  robustMode,
  input  bank_t                 bankSel,
  input  logic [SAMP_BUS_W-1:0] rdSamples,
  input  logic                  thrLoad,
  input  logic [SAMPLE_W-1:0]   thrValue,
  output logic                  rdValid,
  output logic [DATA_W-1:0]     rdData
);

  logic [SAMPLE_W-1:0]   robustThr;
  logic [SAMP_BUS_W-1:0] sampleReg;
  logic [CELLS-1:0]      coarseReg;
  bank_t                 bankReg;
  logic                  lastRobust;

  logic [CELLS-1:0]  coarseNow;
  logic [CELLS-1:0]  robustBits;
  logic [DATA_W-1:0] denseWord;
  logic [DATA_W-1:0] robustWord;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic [SAMPLE_W-1:0] liveS;
    logic [SAMPLE_W-1:0] heldS;
    logic                fineBit;
    always_comb begin
      liveS         = rdSamples[i*SAMPLE_W +: SAMPLE_W];
      heldS         = sampleReg[i*SAMPLE_W +: SAMPLE_W];
      coarseNow[i]  = liveS >= THR_MID;
      robustBits[i] = (liveS >= robustThr) ^ robustInvert(bankSel);
      fineBit       = coarseReg[i] ? (heldS >= THR_HI) : (heldS >= THR_LO);
      denseWord[2*i +: 2] = decodeSym(bankReg, {coarseReg[i], fineBit});
    end
  end

  always_comb begin
    robustWord            = '0;
    robustWord[CELLS-1:0] = robustBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      robustThr  <= THR_ROBUST_RST;
      sampleReg  <= '0;
      coarseReg  <= '0;
      bankReg    <= '0;
      lastRobust <= 1'b0;
      rdValid    <= 1'b0;
      rdData     <= '0;
    end else begin
      if (thrLoad) robustThr <= thrValue;
      if (strobe.capture) begin
        sampleReg  <= rdSamples;
        coarseReg  <= coarseNow;
        bankReg    <= bankSel;
        lastRobust <= robustMode;
      end
      rdValid <= strobe.finishRobust | strobe.finishDense;
      if (strobe.finishRobust)     rdData <= robustWord;
      else if (strobe.finishDense) rdData <= denseWord;
    end
  end

  AST_ROBUST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && lastRobust) |-> (rdData[DATA_W-1:CELLS] == '0)); // R5
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.finishRobust && strobe.finishDense)); // R6

endmodule

// File: rtl/cell_level_codec.sv
module cell_level_codec
  import clc_pkg::*;
#(
  parameter int CELLS    = 4,
  parameter int SAMPLE_W = 8,
  parameter logic [SAMPLE_W-1:0] THR_LO  = 8'd75,
  parameter logic [SAMPLE_W-1:0] THR_MID = 8'd125,
  parameter logic [SAMPLE_W-1:0] THR_HI  = 8'd175,
  parameter logic [SAMPLE_W-1:0] THR_ROBUST_RST = 8'd160,
  localparam int DATA_W = 2 * CELLS,
  localparam int SAMP_BUS_W = CELLS * SAMPLE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  robustMode,
  input  logic [1:0]            bankSel,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     wrLevels,
  input  logic                  thrLoad,
  input  logic [SAMPLE_W-1:0]   thrValue,
  input  logic                  rdStart,
  input  logic [SAMP_BUS_W-1:0] rdSamples,
  output logic                  rdValid,
  output logic [DATA_W-1:0]     rdData
);

  ctrl_strobe_t strobe;

  clc_write_map #(.CELLS(CELLS)) u_wmap (
    .clk(clk), .rstN(rstN), .robustMode(robustMode), .bankSel(bankSel),
    .wrData(wrData), .wrLevels(wrLevels)
  );

  clc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdStart(rdStart), .robustMode(robustMode),
    .rdValid(rdValid), .strobe(strobe)
  );

  clc_datapath #(
    .CELLS(CELLS), .SAMPLE_W(SAMPLE_W), .THR_LO(THR_LO), .THR_MID(THR_MID),
    .THR_HI(THR_HI), .THR_ROBUST_RST(THR_ROBUST_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .robustMode(robustMode),
    .bankSel(bankSel), .rdSamples(rdSamples), .thrLoad(thrLoad),
    .thrValue(thrValue), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: tb/cell_level_codec_tb_top.sv
module cell_level_codec_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        robustMode;
  logic [1:0]  bankSel;
  logic [7:0]  wrData;
  logic [7:0]  wrLevels;
  logic        thrLoad;
  logic [7:0]  thrValue;
  logic        rdStart;
  logic [31:0] rdSamples;
  logic        rdValid;
  logic [7:0]  rdData;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cell_level_codec dut_i (
    .clk(clk), .rstN(rstN), .robustMode(robustMode), .bankSel(bankSel),
    .wrData(wrData), .wrLevels(wrLevels), .thrLoad(thrLoad), .thrValue(thrValue),
    .rdStart(rdStart), .rdSamples(rdSamples), .rdValid(rdValid), .rdData(rdData)
  );

  // {isWrite, bank, robust, payload(samples or data), expected}
  localparam int NVEC = 16;
  localparam logic [43:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 1'b0, 32'hC8966432, 8'hE4},  // R4 all levels bank0
    {1'b0, 2'd1, 1'b0, 32'hC8966432, 8'h1B},  // R4 bank1
    {1'b0, 2'd2, 1'b0, 32'hC8966432, 8'h72},  // R4 bank2
    {1'b0, 2'd0, 1'b0, 32'h7D7C4B4A, 8'h94},  // R4 boundaries 74/75/124/125
    {1'b0, 2'd0, 1'b0, 32'hFF00AFAE, 8'hCE},  // R4 boundaries 174/175, extremes
    {1'b0, 2'd3, 1'b0, 32'hC8966432, 8'hE4},  // R2 bank3 read
    {1'b0, 2'd0, 1'b1, 32'hC832A09F, 8'h0A},  // R5 159/160 bank0
    {1'b0, 2'd1, 1'b1, 32'hC832A09F, 8'h05},  // R5 bank1 inverted
    {1'b0, 2'd2, 1'b1, 32'hC832A09F, 8'h0A},  // R5 bank2
    {1'b1, 2'd0, 1'b0, 32'h000000E4, 8'hE4},  // R1 bank0
    {1'b1, 2'd1, 1'b0, 32'h000000E4, 8'h1B},  // R1 bank1
    {1'b1, 2'd2, 1'b0, 32'h000000E4, 8'h8D},  // R1 bank2
    {1'b1, 2'd3, 1'b0, 32'h000000E4, 8'hE4},  // R2 bank3 write
    {1'b1, 2'd0, 1'b1, 32'h000000F5, 8'h33},  // R3 upper bits ignored
    {1'b1, 2'd1, 1'b1, 32'h000000F5, 8'hCC},  // R3 bank1 swapped
    {1'b1, 2'd2, 1'b1, 32'h0000000A, 8'hCC}   // R3 bank2
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs driven at negedge; result sampled at following negedges
  task automatic doRead(input logic [1:0] bank, input logic robust,
                        input logic [31:0] samp, input logic [7:0] exp, input string req);
    bankSel    = bank;
    robustMode = robust;
    rdSamples  = samp;
    rdStart    = 1'b1;
    @(negedge clk);
    rdStart = 1'b0;
    if (!robust) begin
      check(rdValid == 1'b0, "R6 dense early", {31'd0, rdValid}, 32'd0);
      @(negedge clk);
    end
    check(rdValid == 1'b1, "R6 valid", {31'd0, rdValid}, 32'd1);
    check(rdData == exp, req, {24'd0, rdData}, {24'd0, exp});
    @(negedge clk);
    check(rdValid == 1'b0, "R6 pulse", {31'd0, rdValid}, 32'd0);
  endtask

  initial begin
    rstN = 1'b0; robustMode = 1'b0; bankSel = '0; wrData = '0;
    thrLoad = 1'b0; thrValue = '0; rdStart = 1'b0; rdSamples = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rdValid == 1'b0, "R6 reset valid", {31'd0, rdValid}, 32'd0);
    check(rdData == 8'h00, "R6 reset data", {24'd0, rdData}, 32'd0);

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][43]) begin
        bankSel    = VEC[k][42:41];
        robustMode = VEC[k][40];
        wrData     = VEC[k][15:8];
        #2;
        check(wrLevels == VEC[k][7:0],
              VEC[k][40] ? "R3 robust write" : (VEC[k][42:41] == 2'd3 ? "R2 write" : "R1 dense write"),
              {24'd0, wrLevels}, {24'd0, VEC[k][7:0]});
        @(negedge clk);
      end else begin
        doRead(VEC[k][42:41], VEC[k][40], VEC[k][39:8], VEC[k][7:0],
               VEC[k][40] ? "R5 robust read" : (VEC[k][42:41] == 2'd3 ? "R2 read" : "R4 dense read"));
      end
    end

    // R5: reprogram threshold to 100
    thrValue = 8'd100; thrLoad = 1'b1;
    @(negedge clk);
    thrLoad = 1'b0;
    doRead(2'd0, 1'b1, 32'hC8966463, 8'h0E, "R5 reloaded threshold");

    // R7: captured inputs and ignored start during dense read
    bankSel = 2'd0; robustMode = 1'b0; rdSamples = 32'hC8966432; rdStart = 1'b1;
    @(negedge clk);
    check(rdValid == 1'b0, "R7 busy cycle", {31'd0, rdValid}, 32'd0);
    bankSel = 2'd1; robustMode = 1'b1; rdSamples = 32'h00000000; rdStart = 1'b1;
    @(negedge clk);
    rdStart = 1'b0;
    check(rdValid == 1'b1, "R7 valid", {31'd0, rdValid}, 32'd1);
    check(rdData == 8'hE4, "R7 captured inputs", {24'd0, rdData}, 32'hE4);
    @(negedge clk);
    check(rdValid == 1'b0, "R7 ignored start", {31'd0, rdValid}, 32'd0);
    check(rdData == 8'hE4, "R7 data held", {24'd0, rdData}, 32'hE4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule